// File: doc/BRIEF.md
# Rotating Drum Word Store Controller

This block sits between a data channel and the storage array of a word-addressed rotating drum. Software issues a read-select or a write-select command. The block answers at once with accept, busy or illegal, and on accept it claims the channel in the matching direction. It also starts the drum address at zero.

An angular position counter advances on every word-time strobe. Whenever the next angular position equals the low twelve bits of the drum address, one 36-bit word moves between the channel and the array. For a read, the word goes from the array to the channel. For a write, it goes from the channel to the array. The drum address is a sparse word with three live fields, which is folded into a 21-bit linear array index. After each moved word the address steps forward, and the block flags the end of a record every 2048 words.

Other outcomes at a match are handled as follows:
- If the index names a drum unit that is not installed, the block reports an error and moves nothing.
- If the channel signals the end of a record at a match, or is not ready then, transfers stop.
- A channel disconnect clears the unit completely.

Top module: `drum_ctrl`

## Requirements
- R1: Command code 2'b01 is read-select and 2'b10 is write-select. With the unit idle, any other code answers `cmd_resp` = 2 (illegal), and `chan_sel` stays low.
- R2: While `chan_active` is high, or while an earlier command is still pending, `cmd_resp` = 1 (busy) and the command has no effect.
- R3: An accepted command answers `cmd_resp` = 0. From the next cycle it drives `chan_sel` high and `chan_dir` to 0 for read or 1 for write, and the drum address restarts at 0. After reset `chan_sel`, `mem_we`, `chan_rd_valid` and all status outputs are low.
- R4: The angular position starts at 0 after reset. It advances by one on each cycle with `word_tick` high and wraps modulo 4096. A match compares the advanced position with address bits 11:0.
- R5: A word moves only in a `word_tick` cycle with `chan_active` high, the unit selected, a read or write mode set, and a position match.
- R6: `mem_idx` carries address bits 32:30 in bits 20:18, address bits 20:18 in bits 17:15, and address bits 14:0 in bits 14:0.
- R7: At a match where `mem_idx[20:18]` is not below the installed-unit count (`units_cfg`, sampled during reset), nothing moves. In that cycle `st_eor`, `st_attn` and `st_err` all pulse, and the address stays the same.
- R8: After each moved word, the address steps by one and keeps only bits 32:30, 20:18 and 14:0. `st_eor` pulses in the cycle of the word whose stepped address has its low 11 bits at zero.
- R9: At a match with `chan_end` high, or with `chan_ready` low, nothing moves and the read and write modes drop. The command stays pending, so later commands answer busy. A not-ready match pulses `st_timing`.
- R10: A `word_tick` cycle with `chan_disco` high while a command is pending clears all unit state and drops `chan_sel` from the next cycle. A new command can then be accepted.
- R11: A read word drives `chan_rd_valid` with `chan_rd_data` equal to `mem_rdata` at `mem_idx`. A write word drives `mem_we` and `chan_wr_take` with `mem_wdata` equal to `chan_wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| units_cfg | input | 3 | Installed drum unit count, sampled during reset |
| word_tick | input | 1 | Word-time strobe |
| cmd_valid | input | 1 | Command presented this cycle |
| cmd_code | input | 2 | 01 read-select, 10 write-select |
| cmd_resp | output | 2 | 0 accept, 1 busy, 2 illegal |
| chan_active | input | 1 | Channel is running a transfer |
| chan_disco | input | 1 | Channel disconnect |
| chan_end | input | 1 | Channel signals end of record |
| chan_ready | input | 1 | Channel can take or give a word |
| chan_sel | output | 1 | Unit holds the channel |
| chan_dir | output | 1 | 0 drum to channel, 1 channel to drum |
| chan_rd_valid | output | 1 | Word offered to the channel |
| chan_rd_data | output | 36 | Word to the channel |
| chan_wr_data | input | 36 | Word from the channel |
| chan_wr_take | output | 1 | Channel word consumed |
| st_eor | output | 1 | End-of-record status pulse |
| st_attn | output | 1 | Attention status pulse |
| st_err | output | 1 | Error status pulse |
| st_timing | output | 1 | Timing error pulse |
| mem_idx | output | 21 | Linear storage index |
| mem_we | output | 1 | Storage write enable |
| mem_wdata | output | 36 | Storage write data |
| mem_rdata | input | 36 | Storage read data, same cycle |

## Verification
A wrong drum address or a wrong angular position shows on the very next word. That word appears at the wrong index, or at an angular slot that differs from the one the bench tracks, so the scoreboard catches it within one transfer. A lost mode or pending flag has different visible effects:
- A mode that fails to drop shows as a word moving during the idle revolution that follows.
- A pending flag that clears too early shows as an accept where busy was due.

Both are caught within at most one drum revolution of 4096 word times.

// File: rtl/drum_pkg.sv
package drum_pkg;
  localparam int ADDR_W = 33;
  localparam int IDX_W  = 21;
  localparam logic [ADDR_W-1:0] ADDR_KEEP = 33'h1C01C7FFF;

  localparam logic [1:0] CMD_READ  = 2'b01;
  localparam logic [1:0] CMD_WRITE = 2'b10;

  typedef enum logic [1:0] {
    RESP_OK    = 2'd0,
    RESP_BUSY  = 2'd1,
    RESP_IOERR = 2'd2
  } resp_e;

  function automatic logic [IDX_W-1:0] fold_index(input logic [ADDR_W-1:0] a);
    return {a[32:30], a[20:18], a[14:0]};
  endfunction

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return (a + 1'b1) & ADDR_KEEP;
  endfunction
endpackage

// File: rtl/drum_rotor.sv
module drum_rotor #(
  parameter int POS_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [POS_W-1:0] pos,
  output logic [POS_W-1:0] pos_nxt
);
  logic [POS_W-1:0] pos_q;

  assign pos_nxt = pos_q + 1'b1;
  assign pos     = pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pos_q <= '0;
    else if (tick) pos_q <= pos_nxt;
  end

  a_r4_pos_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> pos == $past(pos) + 1'b1);
  a_r4_pos_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pos));
endmodule

// File: rtl/drum_addr_unit.sv
module drum_addr_unit
  import drum_pkg::*;
#(
  parameter int REC_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic              rec_wrap
);
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_nxt;

  assign addr_nxt = step_addr(addr_q);
  assign addr     = addr_q;
  assign idx      = fold_index(addr_q);
  assign rec_wrap = (addr_nxt[REC_W-1:0] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr_q <= '0;
    else if (clear) addr_q <= '0;
    else if (step)  addr_q <= addr_nxt;
  end

  a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> addr == '0);
  a_r8_field_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear && addr[14:0] == 15'h7FFF) |=>
      (addr[14:0] == '0 && addr[20:18] == $past(addr[20:18])));
endmodule

// File: rtl/drum_ctrl.sv
module drum_ctrl
  import drum_pkg::*;
#(
  parameter int WORD_W = 36,
  parameter int POS_W  = 12,
  parameter int REC_W  = 11,
  parameter int UNIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [UNIT_W-1:0] units_cfg,
  input  logic              word_tick,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_code,
  output logic [1:0]        cmd_resp,
  input  logic              chan_active,
  input  logic              chan_disco,
  input  logic              chan_end,
  input  logic              chan_ready,
  output logic              chan_sel,
  output logic              chan_dir,
  output logic              chan_rd_valid,
  output logic [WORD_W-1:0] chan_rd_data,
  input  logic [WORD_W-1:0] chan_wr_data,
  output logic              chan_wr_take,
  output logic              st_eor,
  output logic              st_attn,
  output logic              st_err,
  output logic              st_timing,
  output logic [IDX_W-1:0]  mem_idx,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata
);
  localparam int UNIT_LSB = IDX_W - UNIT_W;

  logic              rd_mode, wr_mode, pend, sel_q, dir_q;
  logic [UNIT_W-1:0] units_q;
  logic [POS_W-1:0]  pos, pos_nxt;
  logic [ADDR_W-1:0] addr;
  logic              rec_wrap;

  // named internal events
  logic  accept, disco_ev, hit, unit_ok, err_ev, end_ev, tm_ev, xfer;
  resp_e resp;

  drum_rotor #(.POS_W(POS_W)) u_rotor (
    .clk(clk), .rst_n(rst_n), .tick(word_tick), .pos(pos), .pos_nxt(pos_nxt)
  );

  drum_addr_unit #(.REC_W(REC_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .clear(accept), .step(xfer),
    .addr(addr), .idx(mem_idx), .rec_wrap(rec_wrap)
  );

  always_comb begin
    if (chan_active || pend)                               resp = RESP_BUSY;
    else if (cmd_code == CMD_READ || cmd_code == CMD_WRITE) resp = RESP_OK;
    else                                                   resp = RESP_IOERR;
  end
  assign cmd_resp = resp;
  assign accept   = cmd_valid && (resp == RESP_OK);

  assign disco_ev = word_tick && pend && chan_disco;
  assign hit      = word_tick && !disco_ev && (rd_mode || wr_mode) && chan_active &&
                    sel_q && (pos_nxt == addr[POS_W-1:0]);
  assign unit_ok  = mem_idx[IDX_W-1:UNIT_LSB] < units_q;
  assign err_ev   = hit && !unit_ok;
  assign end_ev   = hit && unit_ok && chan_end;
  assign tm_ev    = hit && unit_ok && !chan_end && !chan_ready;
  assign xfer     = hit && unit_ok && !chan_end && chan_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_mode <= 1'b0;
      wr_mode <= 1'b0;
      pend    <= 1'b0;
      sel_q   <= 1'b0;
      dir_q   <= 1'b0;
      units_q <= units_cfg;
    end else if (accept) begin
      rd_mode <= (cmd_code == CMD_READ);
      wr_mode <= (cmd_code == CMD_WRITE);
      pend    <= 1'b1;
      sel_q   <= 1'b1;
      dir_q   <= (cmd_code == CMD_WRITE);
    end else if (disco_ev) begin
      rd_mode <= 1'b0;
      wr_mode <= 1'b0;
      pend    <= 1'b0;
      sel_q   <= 1'b0;
      dir_q   <= 1'b0;
    end else if (end_ev || tm_ev) begin
      rd_mode <= 1'b0;
      wr_mode <= 1'b0;
    end
  end

  assign chan_sel      = sel_q;
  assign chan_dir      = dir_q;
  assign chan_rd_valid = xfer && rd_mode;
  assign chan_rd_data  = mem_rdata;
  assign chan_wr_take  = xfer && wr_mode;
  assign mem_we        = xfer && wr_mode;
  assign mem_wdata     = chan_wr_data;
  assign st_eor        = err_ev || (xfer && rec_wrap);
  assign st_attn       = err_ev;
  assign st_err        = err_ev;
  assign st_timing     = tm_ev;

  // assertions next to the control they guard
  a_r1_illegal_no_claim: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_resp == RESP_IOERR) |=> !chan_sel);
  a_r2_pending_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && pend) |-> cmd_resp == RESP_BUSY);
  a_r3_accept_claims: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_resp == RESP_OK) |=> (chan_sel && pend));
  a_r5_move_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || chan_rd_valid) |-> (word_tick && chan_active && chan_sel));
  a_r7_err_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    st_err |-> (!mem_we && !chan_rd_valid && st_eor && st_attn));
  a_r8_eor_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (st_eor && !st_err) |-> mem_idx[REC_W-1:0] == {REC_W{1'b1}});
  a_r9_end_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (end_ev || tm_ev) |=> (!rd_mode && !wr_mode && pend));
  a_r10_disco_release: assert property (@(posedge clk) disable iff (!rst_n)
    disco_ev |=> (!chan_sel && !pend));
endmodule

// File: tb/test_drum_ctrl.sv
module test_drum_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  units_cfg;
  logic        word_tick, cmd_valid, chan_active, chan_disco, chan_end, chan_ready;
  logic [1:0]  cmd_code, cmd_resp;
  logic        chan_sel, chan_dir, chan_rd_valid, chan_wr_take;
  logic [35:0] chan_rd_data, chan_wr_data, mem_wdata, mem_rdata;
  logic        st_eor, st_attn, st_err, st_timing, mem_we;
  logic [20:0] mem_idx;

  int checks = 0, errors = 0, pops = 0;
  logic [11:0] bpos;

  typedef struct { logic wr; logic [20:0] idx; logic eor; } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  function automatic logic [35:0] wpat(input logic [20:0] i);
    return {15'h2D5A, i};
  endfunction
  function automatic logic [35:0] rpat(input logic [20:0] i);
    return {15'h4C3B, ~i};
  endfunction

  assign chan_wr_data = wpat({9'd0, bpos + 12'd1});
  assign mem_rdata    = rpat(mem_idx);

  drum_ctrl i_drum_ctrl (
    .clk(clk), .rst_n(rst_n), .units_cfg(units_cfg), .word_tick(word_tick),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_resp(cmd_resp),
    .chan_active(chan_active), .chan_disco(chan_disco), .chan_end(chan_end),
    .chan_ready(chan_ready), .chan_sel(chan_sel), .chan_dir(chan_dir),
    .chan_rd_valid(chan_rd_valid), .chan_rd_data(chan_rd_data),
    .chan_wr_data(chan_wr_data), .chan_wr_take(chan_wr_take),
    .st_eor(st_eor), .st_attn(st_attn), .st_err(st_err), .st_timing(st_timing),
    .mem_idx(mem_idx), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // independent angular position model (R4)
  always @(posedge clk) begin
    if (!rst_n)         bpos <= '0;
    else if (word_tick) bpos <= bpos + 12'd1;
  end

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    #2;
    if (rst_n && (mem_we || chan_rd_valid)) begin
      if (q.size() == 0) begin
        chk(1'b0, "R5 unexpected word moved", {43'd0, mem_idx}, 64'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        pops++;
        chk(mem_idx == e.idx, "R6 index", {43'd0, mem_idx}, {43'd0, e.idx});
        chk(mem_idx[11:0] == bpos + 12'd1, "R4 angular slot", {52'd0, mem_idx[11:0]}, {52'd0, bpos + 12'd1});
        chk(st_eor == e.eor, "R8 end of record", {63'd0, st_eor}, {63'd0, e.eor});
        if (e.wr) begin
          chk(mem_we && chan_wr_take && !chan_rd_valid, "R11 write strobes", {61'd0, mem_we, chan_wr_take, chan_rd_valid}, 64'd6);
          chk(mem_wdata == wpat(e.idx), "R11 write data", {28'd0, mem_wdata}, {28'd0, wpat(e.idx)});
        end else begin
          chk(chan_rd_valid && !mem_we, "R11 read strobes", {62'd0, chan_rd_valid, mem_we}, 64'd2);
          chk(chan_rd_data == rpat(e.idx), "R11 read data", {28'd0, chan_rd_data}, {28'd0, rpat(e.idx)});
        end
      end
    end
  end

  task automatic push_range(input logic wr, input int lo, input int hi);
    for (int i = lo; i <= hi; i++) begin
      exp_t e;
      e.wr = wr; e.idx = 21'(i); e.eor = (((i + 1) % 2048) == 0);
      q.push_back(e);
    end
  endtask

  task automatic wait_pops(input int n);
    do begin @(negedge clk); #3; end while (pops < n);
  endtask

  task automatic issue(input logic [1:0] code, input logic [1:0] exp_resp, input string req);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = code;
    #1 chk(cmd_resp == exp_resp, req, {62'd0, cmd_resp}, {62'd0, exp_resp});
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_reset(input logic [2:0] cfg);
    rst_n = 1'b0; units_cfg = cfg;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  initial begin
    int base;
    word_tick = 1'b1; cmd_valid = 1'b0; cmd_code = 2'b00;
    chan_active = 1'b0; chan_disco = 1'b0; chan_end = 1'b0; chan_ready = 1'b1;
    do_reset(3'd1);
    #1;
    chk(!chan_sel && !mem_we && !chan_rd_valid, "R3 reset idle", {61'd0, chan_sel, mem_we, chan_rd_valid}, 64'd0);
    chk(!st_eor && !st_err && !st_attn && !st_timing, "R3 reset status", {60'd0, st_eor, st_err, st_attn, st_timing}, 64'd0);

    issue(2'b11, 2'd2, "R1 illegal code 11");
    issue(2'b00, 2'd2, "R1 illegal code 00");
    #1 chk(!chan_sel, "R1 illegal leaves unit free", {63'd0, chan_sel}, 64'd0);

    chan_active = 1'b1;
    issue(2'b01, 2'd1, "R2 busy while channel active");
    chan_active = 1'b0;
    #1 chk(!chan_sel, "R2 busy has no effect", {63'd0, chan_sel}, 64'd0);

    issue(2'b01, 2'd0, "R3 read accepted");
    #1 chk(chan_sel && !chan_dir, "R3 read claims channel", {62'd0, chan_sel, chan_dir}, 64'd2);
    issue(2'b10, 2'd1, "R2 busy while pending");
    #1 chk(!chan_dir, "R2 pending direction kept", {63'd0, chan_dir}, 64'd0);

    // first words stream from slot 0 after the wrap
    push_range(1'b0, 0, 4);
    chan_active = 1'b1;
    wait_pops(5);
    @(negedge clk) chan_active = 1'b0;
    repeat (4200) @(negedge clk);
    chk(pops == 5, "R5 no words while channel idle", 64'(pops), 64'd5);

    // resume and run through the record boundary
    push_range(1'b0, 5, 2047);
    chan_active = 1'b1;
    wait_pops(2048);
    @(negedge clk) chan_end = 1'b1;
    #1 chk(!mem_we && !chan_rd_valid, "R9 end response moves nothing", {62'd0, mem_we, chan_rd_valid}, 64'd0);
    @(negedge clk) chan_end = 1'b0;
    repeat (4200) @(negedge clk);
    chk(pops == 2048, "R9 modes dropped after end", 64'(pops), 64'd2048);
    chan_active = 1'b0;
    issue(2'b01, 2'd1, "R9 command still pending");

    // disconnect frees the unit
    @(negedge clk) chan_disco = 1'b1;
    @(negedge clk) chan_disco = 1'b0;
    #1 chk(!chan_sel, "R10 select released", {63'd0, chan_sel}, 64'd0);
    issue(2'b10, 2'd0, "R10 new command after disconnect");
    #1 chk(chan_sel && chan_dir, "R3 write claims channel", {62'd0, chan_sel, chan_dir}, 64'd3);

    // write words, then a not-ready channel
    base = pops;
    push_range(1'b1, 0, 2);
    chan_active = 1'b1;
    wait_pops(base + 3);
    @(negedge clk) chan_ready = 1'b0;
    #1 chk(st_timing && !mem_we, "R9 timing error pulse", {62'd0, st_timing, mem_we}, 64'd2);
    @(negedge clk) chan_ready = 1'b1;
    repeat (4200) @(negedge clk);
    chk(pops == base + 3, "R9 modes dropped after timing error", 64'(pops), 64'(base + 3));

    // no installed units: every match is an error
    chan_active = 1'b0;
    do_reset(3'd0);
    issue(2'b01, 2'd0, "R7 read accepted");
    chan_active = 1'b1;
    begin
      int n = 0;
      do begin @(negedge clk); #1; n++; end while (!st_err && n < 5000);
      chk(st_err && st_attn && st_eor, "R7 error status", {61'd0, st_err, st_attn, st_eor}, 64'd7);
      chk(!mem_we && !chan_rd_valid, "R7 nothing moved", {62'd0, mem_we, chan_rd_valid}, 64'd0);
      chk(bpos + 12'd1 == 12'd0, "R7 error at address slot", {52'd0, bpos + 12'd1}, 64'd0);
    end
    chan_active = 1'b0;
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R11 all expected words seen", 64'(q.size()), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", pops);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule